// File: doc/BRIEF.md
# Programmable Memory Bank Address Decoder

This block sits between the processor's external bus requests and the chip-select pins of the memory controller. Each address offered on the request side is compared against a set of pointer registers that software can program. The set covers six ROM/SRAM/flash banks and four DRAM banks, each with a start pointer and a limit pointer. A single further pointer places a 64 KB window that holds four contiguous external I/O banks of 16 KB each. The block drives one active-low select for the winning bank and gives the byte offset inside that bank. It also reports a cacheability flag taken from address bit 26, which plays no part in bank matching.

Pointers are in units of 64 KB. A bank whose start pointer is B and whose limit pointer is L covers addresses from B·2^16 to L·2^16 − 1, so it matches when B ≤ addr[25:16] < L. Software writes pointers through a simple strobe port.

Requests and responses each use a valid/ready handshake with one register stage between them. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or its response is being consumed in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds still and no new request is taken. The configuration port has no handshake.

Top module: `bankdec_top`

## Requirements
- R1: Reset sets every pointer to zero, except that ROM bank 0 gets limit 0x200, so its window is addresses 0 to 32 MB − 1. While `rsp_valid` is low, including after reset, all select outputs are high and `rsp_miss` is low.
- R2: Bank i of the ROM group (i in 0..5) or of the DRAM group (i in 0..3) matches when its start pointer ≤ addr[25:16] < its limit pointer. A match drives bit i of `rsp_rom_sel_n` or of `rsp_dram_sel_n` low.
- R3: For a ROM or DRAM hit, `rsp_offset` equals addr[25:0] minus the start pointer shifted left by 16.
- R4: Address bit 26 is excluded from matching. `rsp_cacheable` is the inverse of address bit 26.
- R5: The I/O window is enabled when its pointer P is nonzero. It matches when addr[25:16] equals P. The I/O bank number is addr[15:14], which drives that bit of `rsp_io_sel_n` low, and `rsp_offset` is addr[13:0].
- R6: When nothing matches, `rsp_miss` is 1, every select is high and `rsp_offset` is 0.
- R7: When several banks match, the lowest-numbered ROM bank wins, then the lowest-numbered DRAM bank, then the I/O window.
- R8: A write with `cfg_we` high uses `cfg_idx` to choose the target: 0..5 selects ROM bank 0..5, 6..9 selects DRAM bank 0..3, and 10 selects the I/O pointer, which takes `cfg_base` only. Indices above 10 change nothing. A request accepted in the same cycle as a write is decoded with the old pointers.
- R9: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. A response stays unchanged while `rsp_valid` is high and `rsp_ready` is low.
- R10: At most one select output is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Pointer write strobe |
| cfg_idx | input | 4 | Pointer register index (R8) |
| cfg_base | input | 10 | Start pointer (64 KB units) |
| cfg_lim | input | 10 | Limit pointer (64 KB units) |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request accepted when high |
| req_addr | input | 27 | Request address; bit 26 is the non-cacheable marker |
| rsp_valid | output | 1 | Decoded response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rom_sel_n | output | 6 | ROM/SRAM/flash bank selects, active low |
| rsp_dram_sel_n | output | 4 | DRAM bank selects, active low |
| rsp_io_sel_n | output | 4 | External I/O bank selects, active low |
| rsp_offset | output | 26 | Byte offset within the selected bank |
| rsp_cacheable | output | 1 | Access is cacheable |
| rsp_miss | output | 1 | No bank matched |

## Verification
On every cycle, the assertions check the following:
- at most one select is low;
- a miss comes with all selects high and a zero offset;
- selects are inactive when idle;
- an I/O hit has an offset below 16 KB;
- a stalled response does not change;
- pointers change only on an in-range write strobe.

Some behaviours can only be shown by the bench's scenarios. These are the range arithmetic and the offset values for each bank, the priority among overlapping banks, the disabling of the I/O window at pointer zero, and the ordering of a pointer write against a request in the same cycle. The bench shows them by sweeping every one of the 1024 pages, with both values of bit 26, against a model it computes itself.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
  localparam int PTR_W  = 10;
  localparam int PAGE_W = 16;
  localparam int OFF_W  = PTR_W + PAGE_W;
  localparam int ADDR_W = OFF_W + 1;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    ptr_t base;
    ptr_t lim;
  } bank_ptr_t;
endpackage

// File: rtl/bankdec_regs.sv
module bankdec_regs
  import bankdec_pkg::*;
#(
  parameter int   N_BANK   = 10,
  parameter ptr_t ROM0_LIM = 10'h200,
  localparam int  IDX_W    = $clog2(N_BANK + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  ptr_t                    cfg_base,
  input  ptr_t                    cfg_lim,
  output bank_ptr_t [N_BANK-1:0]  ptrs,
  output ptr_t                    io_base
);
  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptrs[g].base <= '0;
        ptrs[g].lim  <= (g == 0) ? ROM0_LIM : '0;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        ptrs[g].base <= cfg_base;
        ptrs[g].lim  <= cfg_lim;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) io_base <= '0;
    else if (cfg_we && cfg_idx == IDX_W'(N_BANK)) io_base <= cfg_base;
  end

  // R8: pointers move only on a write strobe
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(ptrs) && $stable(io_base)));

  // R8: out-of-range index leaves everything alone
  assert_idx_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx > IDX_W'(N_BANK)) |=> ($stable(ptrs) && $stable(io_base)));
endmodule

// File: rtl/bankdec_match.sv
module bankdec_match
  import bankdec_pkg::*;
#(
  parameter int N_BANK = 10
) (
  input  ptr_t                    page,
  input  bank_ptr_t [N_BANK-1:0]  ptrs,
  input  ptr_t                    io_base,
  output logic [N_BANK-1:0]       bank_hit,
  output logic                    io_hit
);
  for (genvar g = 0; g < N_BANK; g++) begin : g_cmp
    assign bank_hit[g] = (page >= ptrs[g].base) && (page < ptrs[g].lim);
  end

  assign io_hit = (io_base != '0) && (page == io_base);
endmodule

// File: rtl/bankdec_pick.sv
module bankdec_pick
  import bankdec_pkg::*;
#(
  parameter int  N_ROM  = 6,
  parameter int  N_DRAM = 4,
  parameter int  N_IO   = 4,
  localparam int N_BANK = N_ROM + N_DRAM,
  localparam int BIDX_W = $clog2(N_BANK),
  localparam int IOS_W  = $clog2(N_IO),
  localparam int IOO_W  = PAGE_W - IOS_W
) (
  input  logic [OFF_W-1:0]        addr,
  input  bank_ptr_t [N_BANK-1:0]  ptrs,
  input  logic [N_BANK-1:0]       bank_hit,
  input  logic                    io_hit,
  output logic [N_ROM-1:0]        rom_sel_n,
  output logic [N_DRAM-1:0]       dram_sel_n,
  output logic [N_IO-1:0]         io_sel_n,
  output logic [OFF_W-1:0]        offset,
  output logic                    miss
);
  logic              found;
  logic [BIDX_W-1:0] win;
  logic [N_BANK-1:0] onehot;
  ptr_t              page;
  ptr_t              rel_page;
  logic [IOS_W-1:0]  io_bank;

  assign page    = addr[OFF_W-1:PAGE_W];
  assign io_bank = addr[PAGE_W-1 -: IOS_W];

  // lowest index wins; ROM banks occupy the low indices
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < N_BANK; i++) begin
      if (bank_hit[i] && !found) begin
        found = 1'b1;
        win   = BIDX_W'(i);
      end
    end
  end

  assign rel_page = page - ptrs[win].base;

  always_comb begin
    onehot   = '0;
    io_sel_n = '1;
    offset   = '0;
    miss     = 1'b0;
    if (found) begin
      onehot[win] = 1'b1;
      offset      = {rel_page, addr[PAGE_W-1:0]};
    end else if (io_hit) begin
      io_sel_n[io_bank] = 1'b0;
      offset            = {{(OFF_W-IOO_W){1'b0}}, addr[IOO_W-1:0]};
    end else begin
      miss = 1'b1;
    end
  end

  assign rom_sel_n  = ~onehot[N_ROM-1:0];
  assign dram_sel_n = ~onehot[N_BANK-1:N_ROM];
endmodule

// File: rtl/bankdec_top.sv
module bankdec_top
  import bankdec_pkg::*;
#(
  parameter int   N_ROM    = 6,
  parameter int   N_DRAM   = 4,
  parameter int   N_IO     = 4,
  parameter ptr_t ROM0_LIM = 10'h200
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [$clog2(N_ROM+N_DRAM+1)-1:0]      cfg_idx,
  input  logic [PTR_W-1:0]                       cfg_base,
  input  logic [PTR_W-1:0]                       cfg_lim,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ADDR_W-1:0]                      req_addr,
  output logic                                   rsp_valid,
  input  logic                                   rsp_ready,
  output logic [N_ROM-1:0]                       rsp_rom_sel_n,
  output logic [N_DRAM-1:0]                      rsp_dram_sel_n,
  output logic [N_IO-1:0]                        rsp_io_sel_n,
  output logic [OFF_W-1:0]                       rsp_offset,
  output logic                                   rsp_cacheable,
  output logic                                   rsp_miss
);
  localparam int N_BANK = N_ROM + N_DRAM;
  localparam int IOO_W  = PAGE_W - $clog2(N_IO);

  bank_ptr_t [N_BANK-1:0] ptrs;
  ptr_t                   io_base;
  logic [N_BANK-1:0]      bank_hit;
  logic                   io_hit;
  logic [N_ROM-1:0]       d_rom_n;
  logic [N_DRAM-1:0]      d_dram_n;
  logic [N_IO-1:0]        d_io_n;
  logic [OFF_W-1:0]       d_off;
  logic                   d_miss;
  logic                   accept;

  bankdec_regs #(.N_BANK(N_BANK), .ROM0_LIM(ROM0_LIM)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_lim(cfg_lim), .ptrs(ptrs), .io_base(io_base)
  );

  bankdec_match #(.N_BANK(N_BANK)) u_match (
    .page(req_addr[OFF_W-1:PAGE_W]), .ptrs(ptrs), .io_base(io_base),
    .bank_hit(bank_hit), .io_hit(io_hit)
  );

  bankdec_pick #(.N_ROM(N_ROM), .N_DRAM(N_DRAM), .N_IO(N_IO)) u_pick (
    .addr(req_addr[OFF_W-1:0]), .ptrs(ptrs), .bank_hit(bank_hit),
    .io_hit(io_hit), .rom_sel_n(d_rom_n), .dram_sel_n(d_dram_n),
    .io_sel_n(d_io_n), .offset(d_off), .miss(d_miss)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_rom_sel_n  <= '1;
      rsp_dram_sel_n <= '1;
      rsp_io_sel_n   <= '1;
      rsp_offset     <= '0;
      rsp_cacheable  <= 1'b0;
      rsp_miss       <= 1'b0;
    end else if (accept) begin
      rsp_valid      <= 1'b1;
      rsp_rom_sel_n  <= d_rom_n;
      rsp_dram_sel_n <= d_dram_n;
      rsp_io_sel_n   <= d_io_n;
      rsp_offset     <= d_off;
      rsp_cacheable  <= !req_addr[OFF_W];
      rsp_miss       <= d_miss;
    end else if (rsp_ready) begin
      rsp_valid      <= 1'b0;
      rsp_rom_sel_n  <= '1;
      rsp_dram_sel_n <= '1;
      rsp_io_sel_n   <= '1;
      rsp_offset     <= '0;
      rsp_miss       <= 1'b0;
    end
  end

  assert_one_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{rsp_rom_sel_n, rsp_dram_sel_n, rsp_io_sel_n}));

  assert_miss_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> ((&{rsp_rom_sel_n, rsp_dram_sel_n, rsp_io_sel_n}) && rsp_offset == '0));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ((&{rsp_rom_sel_n, rsp_dram_sel_n, rsp_io_sel_n}) && !rsp_miss));

  assert_io_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(&rsp_io_sel_n)) |-> (rsp_offset < OFF_W'(1 << IOO_W)));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rom_sel_n) && $stable(rsp_dram_sel_n)
      && $stable(rsp_io_sel_n) && $stable(rsp_offset) && $stable(rsp_cacheable) && $stable(rsp_miss)));
endmodule

// File: tb/bankdec_top_test.sv
module bankdec_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [9:0]  cfg_base = '0;
  logic [9:0]  cfg_lim = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [26:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [5:0]  rsp_rom_sel_n;
  logic [3:0]  rsp_dram_sel_n;
  logic [3:0]  rsp_io_sel_n;
  logic [25:0] rsp_offset;
  logic        rsp_cacheable;
  logic        rsp_miss;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [9:0] mb [10];
  logic [9:0] ml [10];
  logic [9:0] mio;

  always #5 clk = ~clk;

  bankdec_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_lim(cfg_lim), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rom_sel_n(rsp_rom_sel_n),
    .rsp_dram_sel_n(rsp_dram_sel_n), .rsp_io_sel_n(rsp_io_sel_n),
    .rsp_offset(rsp_offset), .rsp_cacheable(rsp_cacheable), .rsp_miss(rsp_miss)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [26:0] a, output logic [5:0] er, output logic [3:0] ed,
                       output logic [3:0] ei, output logic [25:0] eo, output logic em);
    logic [9:0] pg;
    bit hit;
    pg = a[25:16];
    er = '1; ed = '1; ei = '1; eo = '0; em = 1'b0; hit = 0;
    for (int i = 0; i < 10; i++) begin
      if (!hit && pg >= mb[i] && pg < ml[i]) begin
        hit = 1;
        if (i < 6) er[i] = 1'b0; else ed[i-6] = 1'b0;
        eo = a[25:0] - {mb[i], 16'h0};
      end
    end
    if (!hit) begin
      if (mio != 0 && pg == mio) begin
        ei[a[15:14]] = 1'b0;
        eo = {12'h0, a[13:0]};
      end else em = 1'b1;
    end
  endtask

  task automatic compare(input logic [26:0] a, input string ctx);
    logic [5:0] er; logic [3:0] ed; logic [3:0] ei; logic [25:0] eo; logic em;
    model(a, er, ed, ei, eo, em);
    chk({ctx, " R9 rsp_valid"}, rsp_valid, 1);
    chk({ctx, " R2/R7 rom sel"}, rsp_rom_sel_n, er);
    chk({ctx, " R2/R7 dram sel"}, rsp_dram_sel_n, ed);
    chk({ctx, " R5 io sel"}, rsp_io_sel_n, ei);
    chk({ctx, " R3 offset"}, rsp_offset, eo);
    chk({ctx, " R4 cacheable"}, rsp_cacheable, !a[26]);
    chk({ctx, " R6 miss"}, rsp_miss, em);
  endtask

  task automatic send(input logic [26:0] a, input string ctx);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    compare(a, ctx);
  endtask

  task automatic wr(input int idx, input logic [9:0] b, input logic [9:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_base = b; cfg_lim = l;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 10) begin mb[idx] = b; ml[idx] = l; end
    else if (idx == 10) mio = b;
  endtask

  task automatic sweep(input string ctx);
    for (int p = 0; p < 1024; p++) begin
      for (int c = 0; c < 2; c++) begin
        logic [15:0] lo;
        lo = {p[1:0], 14'(p * 131 + 7)};
        send({c[0], 10'(p), lo}, ctx);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 10; i++) begin mb[i] = '0; ml[i] = '0; end
    ml[0] = 10'h200; mio = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 selects idle", {rsp_rom_sel_n, rsp_dram_sel_n, rsp_io_sel_n}, 14'h3fff);
    chk("R1 miss idle", rsp_miss, 0);
    chk("R9 req_ready idle", req_ready, 1);

    // R1: reset mapping, ROM0 covers 32 MB
    sweep("R1 reset map");

    // second configuration with overlaps (R7)
    wr(0, 10'h000, 10'h010);
    wr(1, 10'h008, 10'h020);
    wr(2, 10'h100, 10'h140);
    wr(5, 10'h3f0, 10'h3ff);
    wr(6, 10'h200, 10'h300);
    wr(7, 10'h2f0, 10'h310);
    wr(8, 10'h120, 10'h130);
    wr(10, 10'h180, 10'h3ff);
    sweep("R8 config2");

    // R7: I/O window under a DRAM bank loses
    wr(10, 10'h205, 10'h000);
    send({1'b0, 10'h205, 16'h4abc}, "R7 io under dram");
    chk("R7 io loses to dram0", rsp_dram_sel_n, 4'b1110);
    send({1'b1, 10'h180, 16'hc001}, "R5 io moved away");

    // R8: write in the same cycle as a request uses old pointers
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd0; cfg_base = 10'h001; cfg_lim = 10'h004;
    req_valid = 1'b1; req_addr = {1'b0, 10'h006, 16'h1234}; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R8 same-cycle write uses old rom0", rsp_rom_sel_n, 6'b111110);
    chk("R8 same-cycle offset", rsp_offset, 26'h0061234);
    mb[0] = 10'h001; ml[0] = 10'h004;
    send({1'b0, 10'h006, 16'h1234}, "R8 after write");

    // R9: back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_addr = {1'b0, 10'h101, 16'h0010}; rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 stalled req_ready", req_ready, 0);
    req_addr = {1'b1, 10'h205, 16'h0020};
    @(posedge clk);
    @(negedge clk);
    chk("R9 held rom sel", rsp_rom_sel_n, 6'b111011);
    chk("R9 held offset", rsp_offset, 26'h0010010);
    chk("R9 held cacheable", rsp_cacheable, 1);
    rsp_ready = 1'b1;
    #1;
    chk("R9 ready follows rsp_ready", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    compare({1'b1, 10'h205, 16'h0020}, "R9 next after stall");
    @(posedge clk);
    @(negedge clk);
    chk("R1 idle after drain", rsp_valid, 0);
    chk("R1 selects idle after drain", {rsp_rom_sel_n, rsp_dram_sel_n, rsp_io_sel_n}, 14'h3fff);

    // R5: pointer zero disables I/O; R8: index 11 ignored
    wr(10, 10'h000, 10'h000);
    wr(11, 10'h3ff, 10'h3ff);
    wr(15, 10'h000, 10'h3ff);
    send({1'b0, 10'h000, 16'h0000}, "R5 io disabled page0");
    chk("R5 disabled io gives miss", rsp_miss, 1);
    sweep("R8 final");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule